// File: doc/BRIEF.md
# Hardware Store Request Handshake Controller

This controller sits between a shared active-low store-request/busy pad and a memory whose volatile array can be copied into backing storage by a separate store engine. An external agent pulls the pad low to ask for a store. The controller sees that level through a two-flop synchroniser and opens a grace window of a set number of clock cycles. During the window, reads are still served and new writes are refused. When the window closes, the controller starts the engine only if the array has been written since the last completed store or recall.

The pad is open-drain. The block never drives it high; it only asserts a drive-low enable. While any store runs, whether the pad or the internal request line started it, the block holds the pad low as a busy flag. When the engine reports completion, the block releases the pad. It then keeps the array closed to all accesses until it sees the resolved pad level high again. Grants for reads and writes are registered and appear one cycle after the request.

Top module: `store_req_ctrl`

## Requirements
- R1: The pad level reaches the controller through two flops. The first cycle in which the synchronised level is low while the controller is idle opens a grace window of `DELAY` cycles. With the pad pulled low just after edge 0, `eng_start` rises after edge `DELAY+3` and at no earlier edge.
- R2: When the grace window closes, `eng_start` pulses for exactly one cycle, but only if a write was granted since the last store completion or `recall_done`. If no such write exists, the request is ignored and no start is issued.
- R3: A read request is granted (`rd_grant` high in the next cycle) while the controller is idle, during the grace window, and while an ignored request is still pending. At any other time it is refused.
- R4: A write request is granted in the next cycle only while the controller is idle, the synchronised pad level is high and `int_store_req` is low. Every write from the cycle the synchronised level is seen low until it is seen high again is refused.
- R5: `line_drive_low` goes high in the same cycle as `eng_start` and stays high until the cycle after `eng_done`. It is low at every other time.
- R6: After a store completes, no read or write is granted until the synchronised pad level is high again.
- R7: `int_store_req` seen while idle starts a store at once, with no grace window and no dirty condition. It gives the same busy and hold behaviour as a pad-initiated store.
- R8: The dirty condition is set by a granted write and cleared by store completion or by `recall_done`. If a grant and a clear fall in the same cycle, the set wins.
- R9: After synchronous reset, `line_drive_low`, `eng_start`, `rd_grant` and `wr_grant` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Resolved level of the open-drain request/busy pad |
| line_drive_low | output | 1 | Pad drive-low enable (busy indication) |
| rd_req | input | 1 | Read access request strobe |
| rd_grant | output | 1 | Read granted, one cycle after request |
| wr_req | input | 1 | Write access request strobe |
| wr_grant | output | 1 | Write granted, one cycle after request |
| int_store_req | input | 1 | Store request from an internal source |
| recall_done | input | 1 | Pulse: a recall finished, so the array matches backing storage |
| eng_start | output | 1 | One-cycle start pulse to the store engine |
| eng_done | input | 1 | One-cycle completion pulse from the store engine |

## Verification
The bench goes after the following corner cases:
- **Clean array:** a pad request arrives while the array is clean. A design that ignores the dirty condition would start a needless store and hold the pad busy.
- **Write during the grace window:** writes are attempted inside the window. A design that grants them would corrupt data that is about to be copied.
- **Pad held low after completion:** the external agent keeps the pad low after the store finishes. A design that reopens the array on `eng_done` alone would grant accesses too early.
- **Window length and dirty clearing:** the bench measures the edge count from the pad falling to `eng_start`. It also checks that `recall_done` clears a pending write, so a following request is ignored. An internal store on a clean array must still run.

// File: rtl/store_ctl_pkg.sv
package store_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GRACE = 3'd1,
    ST_STORE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_SKIP  = 3'd4
  } hs_state_t;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/dirty_track.sv
module dirty_track (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  always_ff @(posedge clk) begin
    if (rst)        dirty_o <= 1'b0;
    else if (set_i) dirty_o <= 1'b1;
    else if (clr_i) dirty_o <= 1'b0;
  end

  // R8
  dirty_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !dirty_o);
  // R8
  dirty_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> dirty_o);
endmodule

// File: rtl/hsr_fsm.sv
module hsr_fsm
  import store_ctl_pkg::*;
#(
  parameter int DELAY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line_s,
  input  logic dirty,
  input  logic int_req,
  input  logic rd_req,
  input  logic wr_req,
  input  logic eng_done,
  output logic eng_start,
  output logic drive_low,
  output logic rd_grant,
  output logic wr_grant,
  output logic wr_accept,
  output logic xfer_done
);
  localparam int CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

  hs_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             rd_ok;

  assign rd_ok     = (state == ST_IDLE) || (state == ST_GRACE) || (state == ST_SKIP);
  assign wr_accept = wr_req && (state == ST_IDLE) && line_s && !int_req;
  assign xfer_done = (state == ST_STORE) && eng_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      eng_start <= 1'b0;
      drive_low <= 1'b0;
      rd_grant  <= 1'b0;
      wr_grant  <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      rd_grant  <= rd_req && rd_ok;
      wr_grant  <= wr_accept;
      case (state)
        ST_IDLE: begin
          if (int_req) begin
            state     <= ST_STORE;
            eng_start <= 1'b1;
            drive_low <= 1'b1;
          end else if (!line_s) begin
            state <= ST_GRACE;
            cnt   <= '0;
          end
        end
        ST_GRACE: begin
          if (cnt == LAST) begin
            if (dirty) begin
              state     <= ST_STORE;
              eng_start <= 1'b1;
              drive_low <= 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STORE: begin
          if (eng_done) begin
            state     <= ST_HOLD;
            drive_low <= 1'b0;
          end
        end
        ST_HOLD, ST_SKIP: begin
          if (line_s) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  busy_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> drive_low);
  // R5
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_low && eng_done && !eng_start) |=> !drive_low);
  // R1
  grace_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GRACE && cnt != LAST) |=> !eng_start);
  // R4
  wr_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
    wr_grant |-> $past(line_s));
  // R6
  hold_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |=> (!rd_grant && !wr_grant));
  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
endmodule

// File: rtl/store_req_ctrl.sv
module store_req_ctrl #(
  parameter int DELAY       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_drive_low,
  input  logic rd_req,
  output logic rd_grant,
  input  logic wr_req,
  output logic wr_grant,
  input  logic int_store_req,
  input  logic recall_done,
  output logic eng_start,
  input  logic eng_done
);
  logic line_s;
  logic dirty;
  logic wr_accept;
  logic xfer_done;

  line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (line_in),
    .d_out (line_s)
  );

  dirty_track u_dirty (
    .clk     (clk),
    .rst     (rst),
    .set_i   (wr_accept),
    .clr_i   (xfer_done || recall_done),
    .dirty_o (dirty)
  );

  hsr_fsm #(.DELAY(DELAY)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .line_s    (line_s),
    .dirty     (dirty),
    .int_req   (int_store_req),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .eng_done  (eng_done),
    .eng_start (eng_start),
    .drive_low (line_drive_low),
    .rd_grant  (rd_grant),
    .wr_grant  (wr_grant),
    .wr_accept (wr_accept),
    .xfer_done (xfer_done)
  );

  // R2
  clean_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_start && !$past(int_store_req)) |-> $past(dirty));
endmodule

// File: tb/test_store_req_ctrl.sv
module test_store_req_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DELAY      = 8;
  localparam int ENG_CYC    = 20;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_low = 1'b0;
  logic rd_req = 1'b0, wr_req = 1'b0, int_store_req = 1'b0, recall_done = 1'b0;
  logic eng_done = 1'b0;
  logic line_drive_low, rd_grant, wr_grant, eng_start;
  wire  line_in = !(ext_low || line_drive_low);

  int n_tests = 0, n_fail = 0, cycles = 0, starts = 0, ecnt = 0;
  bit  done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_req_ctrl #(.DELAY(DELAY)) i_store_req_ctrl (
    .clk(clk), .rst(rst), .line_in(line_in), .line_drive_low(line_drive_low),
    .rd_req(rd_req), .rd_grant(rd_grant), .wr_req(wr_req), .wr_grant(wr_grant),
    .int_store_req(int_store_req), .recall_done(recall_done),
    .eng_start(eng_start), .eng_done(eng_done));

  // behavioural reference model: mode 0 idle,1 window,2 storing,3 closed,4 ignored
  int mmode = 0, mcount = 0;
  bit mdirty = 0, ms1 = 1, ms2 = 1;
  bit m_start = 0, m_drive = 0, m_rd = 0, m_wr = 0;
  wire mline = !(ext_low || m_drive);

  always @(posedge clk) begin
    bit wr_ok;
    if (rst) begin
      ms1 <= 1; ms2 <= 1; mmode <= 0; mcount <= 0; mdirty <= 0;
      m_start <= 0; m_drive <= 0; m_rd <= 0; m_wr <= 0;
    end else begin
      ms1 <= mline; ms2 <= ms1;
      m_start <= 0;
      m_rd <= rd_req && (mmode == 0 || mmode == 1 || mmode == 4);
      wr_ok = wr_req && mmode == 0 && ms2 && !int_store_req;
      m_wr <= wr_ok;
      if (wr_ok) mdirty <= 1;
      else if ((mmode == 2 && eng_done) || recall_done) mdirty <= 0;
      if (mmode == 0) begin
        if (int_store_req) begin mmode <= 2; m_start <= 1; m_drive <= 1; end
        else if (!ms2) begin mmode <= 1; mcount <= 1; end
      end else if (mmode == 1) begin
        if (mcount == DELAY) begin
          if (mdirty) begin mmode <= 2; m_start <= 1; m_drive <= 1; end
          else mmode <= 4;
        end else mcount <= mcount + 1;
      end else if (mmode == 2) begin
        if (eng_done) begin mmode <= 3; m_drive <= 0; end
      end else begin
        if (ms2) mmode <= 0;
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R5 drive", line_drive_low, m_drive);
      chk("R2 start", eng_start, m_start);
      chk("R3 rd_grant", rd_grant, m_rd);
      chk("R4 wr_grant", wr_grant, m_wr);
    end
    if (eng_start) starts++;
    // store engine model
    eng_done = 1'b0;
    if (eng_start) ecnt = ENG_CYC;
    else if (ecnt > 0) begin
      ecnt--;
      if (ecnt == 0) eng_done = 1'b1;
    end
    if (cycles > WATCHDOG && !done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write();
    wr_req = 1; tick(1); wr_req = 0;
  endtask

  task automatic wait_idle();
    while (line_drive_low || ecnt > 0) tick(1);
    tick(4);
  endtask

  initial begin
    int s0;
    int edges;
    tick(3);
    // R9 reset state
    chk("R9 drive", line_drive_low, 1'b0);
    chk("R9 start", eng_start, 1'b0);
    chk("R9 rd", rd_grant, 1'b0);
    chk("R9 wr", wr_grant, 1'b0);
    rst = 0;
    tick(2);

    // R3/R4 plain reads and writes while idle
    rd_req = 1; tick(1); chk("R3 idle read", rd_grant, 1'b1); rd_req = 0;
    do_write(); chk("R4 idle write", wr_grant, 1'b1);

    // R1 window length, R2 dirty store, R4 writes blocked in window
    s0 = starts;
    ext_low = 1; edges = 0;
    while (!eng_start && edges < 100) begin
      if (edges == 4) wr_req = 1;
      if (edges == 5) begin wr_req = 0; rd_req = 1; end
      if (edges == 6) rd_req = 0;
      tick(1); edges++;
      if (edges == 5) chk("R4 window write refused", wr_grant, 1'b0);
      if (edges == 6) chk("R3 window read granted", rd_grant, 1'b1);
    end
    chk("R1 window edges", edges == DELAY + 3, 1'b1);
    chk("R5 busy at start", line_drive_low, 1'b1);
    // R6 keep pad low past completion: array closed
    while (!eng_done) tick(1);
    tick(3);
    rd_req = 1; wr_req = 1; tick(1);
    chk("R6 closed read", rd_grant, 1'b0);
    chk("R6 closed write", wr_grant, 1'b0);
    rd_req = 0; wr_req = 0;
    chk("R5 released", line_drive_low, 1'b0);
    ext_low = 0; tick(5);
    chk("R2 one start", starts - s0 == 1, 1'b1);

    // R2 clean array: request ignored, reads still served (R3)
    s0 = starts;
    ext_low = 1; tick(DELAY + 8);
    rd_req = 1; tick(1); chk("R3 ignored-state read", rd_grant, 1'b1); rd_req = 0;
    wr_req = 1; tick(1); chk("R4 low write refused", wr_grant, 1'b0); wr_req = 0;
    ext_low = 0; tick(5);
    chk("R2 clean no start", starts == s0, 1'b1);

    // R8 recall clears dirty
    do_write(); recall_done = 1; tick(1); recall_done = 0;
    s0 = starts;
    ext_low = 1; tick(DELAY + 8); ext_low = 0; tick(5);
    chk("R8 recall clears", starts == s0, 1'b1);

    // R8 write and recall in same cycle: set wins
    wr_req = 1; recall_done = 1; tick(1); wr_req = 0; recall_done = 0;
    s0 = starts;
    ext_low = 1; tick(DELAY + 6); ext_low = 0;
    wait_idle();
    chk("R8 set wins", starts - s0 == 1, 1'b1);

    // R7 internal request on clean array starts at once
    s0 = starts;
    int_store_req = 1; wr_req = 1; tick(1); int_store_req = 0; wr_req = 0;
    chk("R7 immediate start", eng_start, 1'b1);
    chk("R7 write refused", wr_grant, 1'b0);
    chk("R7 busy", line_drive_low, 1'b1);
    wait_idle();
    chk("R7 one start", starts - s0 == 1, 1'b1);
    rd_req = 1; tick(1); chk("R6 reopened read", rd_grant, 1'b1); rd_req = 0;

    // mixed traffic
    for (int i = 0; i < 40; i++) begin
      rd_req = (i % 3) == 0; wr_req = (i % 5) == 1;
      ext_low = (i >= 10 && i < 25);
      tick(1);
    end
    rd_req = 0; wr_req = 0; ext_low = 0;
    wait_idle();

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule